// File: doc/BRIEF.md
# Grayscale Window Update Streamer

This block turns a rectangle update request for a 4-bit grayscale dot-matrix panel into the byte stream that the panel controller expects. A request carries a pixel x and y origin plus a width and height. Once accepted, the block first emits a short addressing header as command bytes: a column-range opcode with its start and end byte columns, then a row-range opcode with its first and last row. It then pulls gray pixels from a valid/ready pixel source in row-major order. It packs every two horizontally adjacent pixels into one byte and sends the bytes as one unbroken data burst, because the panel advances its write address horizontally and wraps at the window edge.

A clear request ignores the supplied rectangle. It addresses the whole panel and sends zero bytes for every byte column of every row without touching the pixel source. Requests that reach past the panel edge or that have an empty size are refused with a one-cycle reject pulse. While a transfer is running, the request input is not looked at.

The output is a byte port with a valid/ready handshake and a data/command flag. It is meant to feed a serial link master that sits outside this block.

Top module: `gray_window_streamer`

## Requirements
- R1: A non-clear request is legal only when width ≥ 1, height ≥ 1, x + width ≤ PANEL_W and y + height ≤ PANEL_H. An illegal request seen while idle raises `req_reject` for exactly one cycle, in the cycle after it is sampled. `busy` stays low and no byte is sent.
- R2: After acceptance the first six bytes go out with `tx_dc` = 0, in this order: 0x15, x/2, x/2 + ceil(width/2) − 1, 0x75, y, y + height − 1.
- R3: The header is followed by exactly ceil(width/2) × height bytes, all with `tx_dc` = 1. No command byte is sent between them.
- R4: Pixels are taken in row-major order, width × height of them. In each data byte, bits 3:0 hold the even (left) pixel of the pair and bits 7:4 hold the next pixel.
- R5: When the width is odd, the last byte of every row carries the row's final pixel in bits 3:0 and zero in bits 7:4.
- R6: A clear request ignores x, y, width and height. It sends the header for the full panel (0, ceil(PANEL_W/2) − 1, 0, PANEL_H − 1) and then ceil(PANEL_W/2) × PANEL_H zero bytes, and `pix_ready` stays low throughout.
- R7: `busy` rises in the cycle after acceptance and falls in the cycle after the last data byte's handshake. Requests presented while busy neither raise `req_reject` nor alter the transfer in progress.
- R8: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_byte` and `tx_dc` hold their values into the next cycle.
- R9: After reset and whenever `busy` is low, `tx_valid`, `pix_ready` and `req_reject` are low, apart from the reject pulse of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Update request strobe, sampled while idle |
| req_clear | input | 1 | Request is a full-panel clear |
| req_x | input | XW | Left pixel column of the window |
| req_y | input | YW | Top row of the window |
| req_w | input | XW | Window width in pixels |
| req_h | input | YW | Window height in rows |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| busy | output | 1 | Transfer in progress |
| pix_valid | input | 1 | Pixel source has a pixel |
| pix_data | input | 4 | Gray level of the offered pixel |
| pix_ready | output | 1 | Block takes the offered pixel |
| tx_valid | output | 1 | Byte on `tx_byte` is offered |
| tx_byte | output | 8 | Command or data byte |
| tx_dc | output | 1 | 0 for command/argument bytes, 1 for pixel data |
| tx_ready | input | 1 | Downstream takes the byte |

## Verification
The bench builds the block for a 16 × 8 pixel panel. This keeps every window short enough that rectangles touching all four panel edges, single-pixel widths, odd widths at odd x origins, and a full-panel clear each run in a few hundred cycles. With the small panel, windows that overrun the right or bottom edge by one pixel can be produced directly. Random backpressure on both handshakes then exercises the hold behaviour and the packing of each pair across stalls.

// File: rtl/gws_pkg.sv
package gws_pkg;

    localparam logic [7:0] OP_COL_WINDOW = 8'h15;
    localparam logic [7:0] OP_ROW_WINDOW = 8'h75;
    localparam int         HDR_BYTES     = 6;
    localparam int         CNT_W         = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA
    } stream_state_t;

    typedef struct packed {
        logic [7:0]       col_first;
        logic [7:0]       col_last;
        logic [7:0]       row_first;
        logic [7:0]       row_last;
        logic [CNT_W-1:0] byte_cols;
        logic [CNT_W-1:0] rows;
        logic             odd_width;
        logic             is_clear;
    } window_t;

    function automatic logic [7:0] header_byte(input logic [2:0] idx, input window_t w);
        logic [7:0] b;
        case (idx)
            3'd0:    b = OP_COL_WINDOW;
            3'd1:    b = w.col_first;
            3'd2:    b = w.col_last;
            3'd3:    b = OP_ROW_WINDOW;
            3'd4:    b = w.row_first;
            default: b = w.row_last;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/gws_req_check.sv
module gws_req_check
    import gws_pkg::*;
#(
    parameter int PANEL_W = 128,
    parameter int PANEL_H = 64,
    parameter int XW      = 8,
    parameter int YW      = 7
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] w,
    input  logic [YW-1:0] h,
    input  logic          clear,
    output logic          ok,
    output window_t       win
);

    localparam int SW = 12;

    logic [SW-1:0] xs, ys, ws, hs, x_end, y_end, cols;

    always_comb begin
        xs = SW'(x);
        ys = SW'(y);
        ws = SW'(w);
        hs = SW'(h);
        if (clear) begin
            xs = '0;
            ys = '0;
            ws = SW'(PANEL_W);
            hs = SW'(PANEL_H);
        end
        x_end = xs + ws;
        y_end = ys + hs;
        cols  = (ws + SW'(1)) >> 1;
        ok    = clear || ((ws != '0) && (hs != '0) &&
                          (x_end <= SW'(PANEL_W)) && (y_end <= SW'(PANEL_H)));

        win.col_first = 8'(xs >> 1);
        win.col_last  = 8'((xs >> 1) + cols - SW'(1));
        win.row_first = 8'(ys);
        win.row_last  = 8'(y_end - SW'(1));
        win.byte_cols = CNT_W'(cols);
        win.rows      = CNT_W'(hs);
        win.odd_width = ws[0];
        win.is_clear  = clear;
    end

    // R2: an accepted window never has its end address before its start
    always_comb begin
        if (ok) begin
            p_window_order_r2: assert (win.row_last >= win.row_first &&
                                       win.col_last >= win.col_first);
        end
    end

endmodule

// File: rtl/gws_scan.sv
module gws_scan
    import gws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] byte_cols,
    input  logic [CNT_W-1:0] rows,
    input  logic             step,
    output logic             last_col,
    output logic             last_byte
);

    logic [CNT_W-1:0] col_q, row_q, col_max, row_max;
    logic             active;

    assign last_col  = (col_q == col_max);
    assign last_byte = last_col && (row_q == row_max);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q   <= '0;
            row_q   <= '0;
            col_max <= '0;
            row_max <= '0;
            active  <= 1'b0;
        end else if (load) begin
            col_q   <= '0;
            row_q   <= '0;
            col_max <= byte_cols - CNT_W'(1);
            row_max <= rows - CNT_W'(1);
            active  <= 1'b1;
        end else if (step) begin
            if (last_col) begin
                col_q <= '0;
                row_q <= row_q + CNT_W'(1);
            end else begin
                col_q <= col_q + CNT_W'(1);
            end
            if (last_byte) active <= 1'b0;
        end
    end

    // R3: no byte is counted past the end of the window
    p_step_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        step |-> active);

endmodule

// File: rtl/gws_packer.sv
module gws_packer (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       en,
    input  logic       pix_valid,
    input  logic [3:0] pix_data,
    output logic       pix_ready,
    input  logic       row_end_odd,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    input  logic       byte_take
);

    logic       half_q;
    logic [3:0] low_q;
    logic       full_q;
    logic [7:0] byte_q;
    logic       pix_fire;

    assign pix_ready  = en && !full_q;
    assign pix_fire   = pix_valid && pix_ready;
    assign byte_valid = en && full_q;
    assign byte_data  = byte_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            half_q <= 1'b0;
            low_q  <= '0;
            full_q <= 1'b0;
            byte_q <= '0;
        end else begin
            if (byte_take) full_q <= 1'b0;
            if (pix_fire) begin
                if (half_q) begin
                    byte_q <= {pix_data, low_q};
                    full_q <= 1'b1;
                    half_q <= 1'b0;
                end else if (row_end_odd) begin
                    byte_q <= {4'h0, pix_data};
                    full_q <= 1'b1;
                end else begin
                    low_q  <= pix_data;
                    half_q <= 1'b1;
                end
            end
        end
    end

    // R5: a lone pixel at an odd row end is padded with zero above it
    p_odd_pad_r5: assert property (@(posedge clk) disable iff (rst || start)
        (pix_fire && !half_q && row_end_odd) |=> (byte_valid && byte_data[7:4] == 4'h0));

    // R4: the second pixel of a pair lands in the upper nibble
    p_pair_high_r4: assert property (@(posedge clk) disable iff (rst || start)
        (pix_fire && half_q) |=> (byte_data[7:4] == $past(pix_data)));

endmodule

// File: rtl/gray_window_streamer.sv
module gray_window_streamer
    import gws_pkg::*;
#(
    parameter  int PANEL_W = 128,
    parameter  int PANEL_H = 64,
    localparam int XW      = $clog2(PANEL_W + 1),
    localparam int YW      = $clog2(PANEL_H + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_clear,
    input  logic [XW-1:0] req_x,
    input  logic [YW-1:0] req_y,
    input  logic [XW-1:0] req_w,
    input  logic [YW-1:0] req_h,
    output logic          req_reject,
    output logic          busy,
    input  logic          pix_valid,
    input  logic [3:0]    pix_data,
    output logic          pix_ready,
    output logic          tx_valid,
    output logic [7:0]    tx_byte,
    output logic          tx_dc,
    input  logic          tx_ready
);

    stream_state_t state_q;
    window_t       win_c, win_q;
    logic          req_ok;
    logic [2:0]    hdr_idx_q;
    logic          accept, tx_fire, data_fire;
    logic          last_col, last_byte;
    logic          pk_valid;
    logic [7:0]    pk_byte;
    logic          pk_en;

    gws_req_check #(
        .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .XW(XW), .YW(YW)
    ) u_check (
        .x(req_x), .y(req_y), .w(req_w), .h(req_h),
        .clear(req_clear), .ok(req_ok), .win(win_c)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid && req_ok;
    assign tx_fire   = tx_valid && tx_ready;
    assign data_fire = tx_fire && (state_q == ST_DATA);
    assign pk_en     = (state_q == ST_DATA) && !win_q.is_clear;
    assign busy      = (state_q != ST_IDLE);

    gws_scan u_scan (
        .clk(clk), .rst(rst), .load(accept),
        .byte_cols(win_c.byte_cols), .rows(win_c.rows),
        .step(data_fire), .last_col(last_col), .last_byte(last_byte)
    );

    gws_packer u_packer (
        .clk(clk), .rst(rst), .start(accept), .en(pk_en),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .row_end_odd(last_col && win_q.odd_width),
        .byte_valid(pk_valid), .byte_data(pk_byte),
        .byte_take(data_fire && !win_q.is_clear)
    );

    always_comb begin
        tx_valid = 1'b0;
        tx_byte  = 8'h00;
        tx_dc    = 1'b0;
        case (state_q)
            ST_HDR: begin
                tx_valid = 1'b1;
                tx_byte  = header_byte(hdr_idx_q, win_q);
            end
            ST_DATA: begin
                tx_dc    = 1'b1;
                tx_valid = win_q.is_clear ? 1'b1 : pk_valid;
                tx_byte  = win_q.is_clear ? 8'h00 : pk_byte;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            win_q      <= '0;
            hdr_idx_q  <= '0;
            req_reject <= 1'b0;
        end else begin
            req_reject <= (state_q == ST_IDLE) && req_valid && !req_ok;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        win_q     <= win_c;
                        hdr_idx_q <= '0;
                        state_q   <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (tx_fire) begin
                        if (hdr_idx_q == 3'(HDR_BYTES - 1)) state_q <= ST_DATA;
                        hdr_idx_q <= hdr_idx_q + 3'd1;
                    end
                end
                ST_DATA: begin
                    if (data_fire && last_byte) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: nothing is offered on either side while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!tx_valid && !pix_ready));

    // R8: an offered byte is held until taken
    p_hold_byte_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_dc)));

    // R7: busy only drops right after a data byte handshake
    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tx_valid && tx_ready && tx_dc));

    // R1: a reject pulse never coincides with a started transfer
    p_reject_idle_r1: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> !busy);

    // R6: a clear never pulls pixels
    p_clear_no_pix_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && win_q.is_clear) |-> !pix_ready);

endmodule

// File: tb/gray_window_streamer_bench.sv
module gray_window_streamer_bench;

    localparam int PW = 16;
    localparam int PH = 8;
    localparam int XW = $clog2(PW + 1);
    localparam int YW = $clog2(PH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_clear = 1'b0;
    logic [XW-1:0] req_x = '0, req_w = '0;
    logic [YW-1:0] req_y = '0, req_h = '0;
    logic          req_reject, busy;
    logic          pix_valid = 1'b0;
    logic [3:0]    pix_data = '0;
    logic          pix_ready;
    logic          tx_valid, tx_dc;
    logic [7:0]    tx_byte;
    logic          tx_ready = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int wd    = 0;
    bit done  = 0;

    logic [3:0] pix_mem [0:255];
    logic [8:0] exp_mem [0:255];
    int         n_exp;

    always #10 clk = ~clk;

    gray_window_streamer #(.PANEL_W(PW), .PANEL_H(PH)) u_gray_window_streamer (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_clear(req_clear),
        .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
        .req_reject(req_reject), .busy(busy),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_dc(tx_dc), .tx_ready(tx_ready)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R7: actual %0d cycles expected below 150000", wd);
            summary();
            $finish;
        end
    end

    function automatic void build_expect(input int x, input int y, input int w,
                                         input int h, input bit clr);
        int cols, k;
        if (clr) begin x = 0; y = 0; w = PW; h = PH; end
        cols = (w + 1) / 2;
        exp_mem[0] = {1'b0, 8'h15};
        exp_mem[1] = {1'b0, 8'(x / 2)};
        exp_mem[2] = {1'b0, 8'(x / 2 + cols - 1)};
        exp_mem[3] = {1'b0, 8'h75};
        exp_mem[4] = {1'b0, 8'(y)};
        exp_mem[5] = {1'b0, 8'(y + h - 1)};
        k = 6;
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < cols; c++) begin
                logic [3:0] lo, hi;
                lo = clr ? 4'h0 : pix_mem[r * w + 2 * c];
                hi = (clr || (2 * c + 1 >= w)) ? 4'h0 : pix_mem[r * w + 2 * c + 1];
                exp_mem[k] = {1'b1, hi, lo};
                k++;
            end
        end
        n_exp = k;
    endfunction

    task automatic run_req(input int x, input int y, input int w, input int h,
                           input bit clr, input bit intrude);
        int got, pk, cyc, rej_seen, clr_pix;
        bit stall_prev;
        logic [8:0] prev;
        for (int i = 0; i < 256; i++) pix_mem[i] = 4'($urandom % 16);
        build_expect(x, y, w, h, clr);
        @(negedge clk);
        req_valid = 1'b1; req_clear = clr;
        req_x = XW'(x); req_y = YW'(y); req_w = XW'(w); req_h = YW'(h);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
        got = 0; pk = 0; cyc = 0; rej_seen = 0; clr_pix = 0;
        stall_prev = 0; prev = '0;
        while (got < n_exp && cyc < 4000) begin
            tx_ready  = ($urandom % 4) != 0;
            pix_valid = ($urandom % 3) != 0;
            pix_data  = pix_mem[pk % 256];
            if (intrude && (cyc == 2 || cyc == 3)) begin
                req_valid = 1'b1;
                req_clear = 1'b0;
                req_x = '0; req_y = '0; req_h = YW'(1);
                req_w = (cyc == 2) ? '0 : XW'(2);
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (stall_prev)
                check(tx_valid && {tx_dc, tx_byte} == prev, "R8", "held byte",
                      int'({tx_valid, tx_dc, tx_byte}), int'({1'b1, prev}));
            if (req_reject) rej_seen++;
            if (clr && pix_ready) clr_pix++;
            if (tx_valid && tx_ready) begin
                if (got < 6)
                    check({tx_dc, tx_byte} == exp_mem[got], "R2", "header byte",
                          int'({tx_dc, tx_byte}), int'(exp_mem[got]));
                else
                    check({tx_dc, tx_byte} == exp_mem[got], clr ? "R6" : "R4",
                          "data byte", int'({tx_dc, tx_byte}), int'(exp_mem[got]));
                got++;
            end
            stall_prev = tx_valid && !tx_ready;
            prev = {tx_dc, tx_byte};
            if (pix_valid && pix_ready) pk++;
            @(negedge clk);
            cyc++;
        end
        tx_ready = 1'b0; pix_valid = 1'b0; req_valid = 1'b0;
        #1;
        check(got == n_exp, "R3", "byte count", got, n_exp);
        check(busy == 1'b0, "R7", "busy after last byte", int'(busy), 0);
        check(tx_valid == 1'b0, "R3", "no extra byte", int'(tx_valid), 0);
        check(pk == (clr ? 0 : w * h), "R4", "pixels consumed", pk, clr ? 0 : w * h);
        if (clr) check(clr_pix == 0, "R6", "pix_ready in clear", clr_pix, 0);
        if (intrude) check(rej_seen == 0, "R7", "reject while busy", rej_seen, 0);
    endtask

    task automatic bad_req(input int x, input int y, input int w, input int h);
        @(negedge clk);
        req_valid = 1'b1; req_clear = 1'b0;
        req_x = XW'(x); req_y = YW'(y); req_w = XW'(w); req_h = YW'(h);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check(req_reject == 1'b1, "R1", "reject pulse", int'(req_reject), 1);
        check(busy == 1'b0, "R1", "busy on illegal", int'(busy), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            check(!tx_valid && !req_reject, "R1", "quiet after reject",
                  int'({tx_valid, req_reject}), 0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check(!busy && !tx_valid && !pix_ready && !req_reject, "R9", "reset state",
              int'({busy, tx_valid, pix_ready, req_reject}), 0);

        run_req(0, 0, PW, PH, 1'b0, 1'b0);     // R2 R3 full panel
        run_req(PW - 1, 3, 1, 2, 1'b0, 1'b0);  // R5 single column at right edge
        run_req(3, 2, 5, 3, 1'b0, 1'b0);       // R5 odd width at odd x
        run_req(2, PH - 1, 6, 1, 1'b0, 1'b0);  // R4 bottom row only
        run_req(5, 1, 0, 0, 1'b1, 1'b0);       // R6 clear ignores window
        run_req(4, 4, 4, 2, 1'b0, 1'b1);       // R7 requests while busy

        bad_req(0, 0, 0, 2);                   // R1 zero width
        bad_req(0, 0, 2, 0);                   // R1 zero height
        bad_req(9, 0, 8, 1);                   // R1 past right edge
        bad_req(0, 5, 2, 4);                   // R1 past bottom edge

        for (int t = 0; t < 12; t++) begin
            int w, h, x, y;
            w = 1 + int'($urandom % PW);
            h = 1 + int'($urandom % PH);
            x = int'($urandom % (PW - w + 1));
            y = int'($urandom % (PH - h + 1));
            run_req(x, y, w, h, 1'b0, 1'b0);
        end

        done = 1;
        summary();
        $finish;
    end

endmodule